// File: doc/BRIEF.md
# Set-Less-Than and Conditional Move Unit

This unit sits in the execute stage of a 32-bit RISC pipeline. It covers two instruction families. The first is compare-and-set: a register is compared with another register, or with a 16-bit immediate, as signed or as unsigned values, and the result is 1 or 0. The second is the conditional move, which copies the first source operand to the destination only when the second source is zero, or only when it is nonzero. The unit takes the decoded opcode and funct fields, both source operand values, the immediate and the current value of the destination register. It returns the value to write and a write-enable.

The compare and move logic is combinational. Its result is captured in one output register, so the outputs are valid one clock after the inputs are presented. When a conditional move does not fire, the write-enable is low and the result port carries the destination's current value. A writeback path that ignores the enable therefore cannot corrupt the register. Opcode and funct combinations outside the supported set give a zero result with the write-enable low.

Top module: `slt_cmov_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `wr_en_o` are 0. After reset, each input set appears on the outputs exactly one rising clock edge later.
- R2: Opcode 0x00 with funct 0x2a compares rs and rt as two's-complement values. It gives `wr_en_o`=1 and `result_o`=1 when rs < rt, otherwise `result_o`=0.
- R3: Opcode 0x00 with funct 0x2b performs the same compare as R2 but on unsigned values, with `wr_en_o`=1.
- R4: Opcode 0x0a sign-extends the immediate to the data width and compares rs against it as signed values. It gives `wr_en_o`=1 and a result of 1 or 0.
- R5: Opcode 0x0b sign-extends the immediate in the same way and then compares as unsigned values. For example, an immediate of 0x8000 becomes 0xFFFF8000. The output has `wr_en_o`=1.
- R6: Opcode 0x00 with funct 0x0a and rt equal to zero gives `wr_en_o`=1 and `result_o`=rs.
- R7: Opcode 0x00 with funct 0x0b and rt not equal to zero gives `wr_en_o`=1 and `result_o`=rs.
- R8: A conditional move whose condition fails gives `wr_en_o`=0 and `result_o` equal to `dest_old_i`.
- R9: Any other opcode/funct combination gives `wr_en_o`=0 and `result_o`=0.
- R10: With rs = 1 and rt = all ones, the signed register compare gives 0 and the unsigned register compare gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used when the opcode is 0x00 |
| rs_val_i | input | DATA_W | First source operand value |
| rt_val_i | input | DATA_W | Second source operand value |
| imm_i | input | IMM_W | Immediate field of the immediate compares |
| dest_old_i | input | DATA_W | Current value of the destination register |
| result_o | output | DATA_W | Value to write back |
| wr_en_o | output | 1 | Write-enable for the destination |

## Verification
The bench builds two instances.

The first uses the default 32-bit data width and 16-bit immediate, with the borrow-based comparator. Directed vectors on it reach the values where the sign bit matters: all ones against 1, an immediate of 0x8000, and a top-bit-only rt for the nonzero move.

The second uses a 4-bit data width, a 3-bit immediate and the direct-relational comparator. This small size lets the bench sweep every rs/rt pair for each register-form instruction and every rs/immediate pair for each immediate form. It also sweeps every opcode and funct code outside the supported set. Expected values come from integer arithmetic in the bench.

// File: rtl/slt_cmov_pkg.sv
package slt_cmov_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0a;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0b;

    localparam logic [FN_W-1:0] FN_SLT  = 6'h2a;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2b;
    localparam logic [FN_W-1:0] FN_MOVZ = 6'h0a;
    localparam logic [FN_W-1:0] FN_MOVN = 6'h0b;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SLT   = 3'd1,
        K_SLTU  = 3'd2,
        K_SLTI  = 3'd3,
        K_SLTIU = 3'd4,
        K_MOVZ  = 3'd5,
        K_MOVN  = 3'd6
    } op_kind_e;

    function automatic logic kind_is_compare(input op_kind_e k);
        return (k == K_SLT) || (k == K_SLTU) || (k == K_SLTI) || (k == K_SLTIU);
    endfunction

    function automatic logic kind_is_move(input op_kind_e k);
        return (k == K_MOVZ) || (k == K_MOVN);
    endfunction

endpackage

// File: rtl/slt_decode.sv
module slt_decode
    import slt_cmov_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output op_kind_e         kind_o
);

    always_comb begin
        kind_o = K_NONE;
        case (opcode_i)
            OPC_RTYPE: begin
                case (funct_i)
                    FN_SLT:  kind_o = K_SLT;
                    FN_SLTU: kind_o = K_SLTU;
                    FN_MOVZ: kind_o = K_MOVZ;
                    FN_MOVN: kind_o = K_MOVN;
                    default: kind_o = K_NONE;
                endcase
            end
            OPC_SLTI:  kind_o = K_SLTI;
            OPC_SLTIU: kind_o = K_SLTIU;
            default:   kind_o = K_NONE;
        endcase
    end

endmodule

// File: rtl/slt_imm_ext.sv
module slt_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] ext_o
);

    localparam int PAD_W = DATA_W - IMM_W;

    generate
        if (PAD_W > 0) begin : g_pad
            // Sign extension applies to both the signed and unsigned compares.
            assign ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign ext_o = imm_i[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/slt_cmp.sv
module slt_cmp #(
    parameter int W          = 32,
    parameter bit USE_BORROW = 1'b1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic         lt_o
);

    generate
        if (USE_BORROW) begin : g_borrow
            // One subtractor serves both forms: its borrow is the unsigned
            // answer, and it is also the signed answer when the sign bits agree.
            logic [W:0] diff;
            logic       sign_split;
            assign diff       = {1'b0, a_i} - {1'b0, b_i};
            assign sign_split = a_i[W-1] ^ b_i[W-1];
            assign lt_o       = (signed_i && sign_split) ? a_i[W-1] : diff[W];
        end else begin : g_direct
            assign lt_o = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
        end
    endgenerate

endmodule

// File: rtl/slt_cmov_unit.sv
module slt_cmov_unit
    import slt_cmov_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IMM_W      = 16,
    parameter bit USE_BORROW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        opcode_i,
    input  logic [5:0]        funct_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [DATA_W-1:0] rt_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] dest_old_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o
);

    localparam int FLAG_PAD = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
    } out_t;

    op_kind_e          kind;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] cmp_b;
    logic              use_signed;
    logic              lt;
    logic              rt_zero;
    out_t              out_d;
    out_t              out_q;

    slt_decode u_dec (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .kind_o   (kind)
    );

    slt_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_i (imm_i),
        .ext_o (imm_ext)
    );

    assign cmp_b      = ((kind == K_SLTI) || (kind == K_SLTIU)) ? imm_ext : rt_val_i;
    assign use_signed = (kind == K_SLT) || (kind == K_SLTI);
    assign rt_zero    = (rt_val_i == '0);

    slt_cmp #(.W(DATA_W), .USE_BORROW(USE_BORROW)) u_cmp (
        .a_i      (rs_val_i),
        .b_i      (cmp_b),
        .signed_i (use_signed),
        .lt_o     (lt)
    );

    always_comb begin
        out_d = '0;
        case (kind)
            K_SLT, K_SLTU, K_SLTI, K_SLTIU: begin
                out_d.we  = 1'b1;
                out_d.res = {{FLAG_PAD{1'b0}}, lt};
            end
            K_MOVZ: begin
                out_d.we  = rt_zero;
                out_d.res = rt_zero ? rs_val_i : dest_old_i;
            end
            K_MOVN: begin
                out_d.we  = !rt_zero;
                out_d.res = rt_zero ? dest_old_i : rs_val_i;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign wr_en_o  = out_q.we;

    // Set one edge after reset leaves, so $past never reaches into reset.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    p_flag_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && kind_is_compare($past(kind))
        |-> wr_en_o && (result_o[DATA_W-1:1] == '0));

    p_sign_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(kind) == K_SLT)
            && ($past(rs_val_i[DATA_W-1]) != $past(rt_val_i[DATA_W-1]))
        |-> result_o[0] == $past(rs_val_i[DATA_W-1]));

    p_movz_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(kind) == K_MOVZ) && ($past(rt_val_i) == '0)
        |-> wr_en_o && (result_o == $past(rs_val_i)));

    p_move_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && kind_is_move($past(kind)) && !wr_en_o
        |-> result_o == $past(dest_old_i));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(kind) == K_NONE)
        |-> !wr_en_o && (result_o == '0));

endmodule

// File: tb/slt_cmov_unit_tb.sv
module slt_cmov_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam int SI = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // 32-bit instance
    logic [5:0]  b_op = '0, b_fn = '0;
    logic [31:0] b_rs = '0, b_rt = '0, b_old = '0;
    logic [15:0] b_imm = '0;
    logic [31:0] b_res;
    logic        b_we;

    // small instance
    logic [5:0]    s_op = '0, s_fn = '0;
    logic [SW-1:0] s_rs = '0, s_rt = '0, s_old = '0;
    logic [SI-1:0] s_imm = '0;
    logic [SW-1:0] s_res;
    logic          s_we;

    slt_cmov_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opcode_i(b_op), .funct_i(b_fn),
        .rs_val_i(b_rs), .rt_val_i(b_rt), .imm_i(b_imm), .dest_old_i(b_old),
        .result_o(b_res), .wr_en_o(b_we)
    );

    slt_cmov_unit #(.DATA_W(SW), .IMM_W(SI), .USE_BORROW(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .opcode_i(s_op), .funct_i(s_fn),
        .rs_val_i(s_rs), .rt_val_i(s_rt), .imm_i(s_imm), .dest_old_i(s_old),
        .result_o(s_res), .wr_en_o(s_we)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_big(input string tag, input logic [5:0] op, input logic [5:0] fn,
                           input logic [31:0] rs, input logic [31:0] rt, input logic [15:0] imm,
                           input logic [31:0] old, input logic [31:0] exp_res, input logic exp_we);
        b_op = op; b_fn = fn; b_rs = rs; b_rt = rt; b_imm = imm; b_old = old;
        @(negedge clk);
        check(tag, {b_we, b_res}, {exp_we, exp_res});
    endtask

    function automatic int sval(input logic [SW-1:0] v);
        return v[SW-1] ? int'(v) - (1 << SW) : int'(v);
    endfunction

    task automatic run_small(input logic [5:0] op, input logic [5:0] fn, input logic [SW-1:0] rs,
                             input logic [SW-1:0] rt, input logic [SI-1:0] imm);
        logic [SW-1:0] old;
        logic [SW-1:0] immx;
        logic [SW-1:0] er;
        logic          ew;
        string         tag;
        old  = rs ^ 4'h9;
        immx = {imm[SI-1], imm};
        er = '0; ew = 1'b0; tag = "R9 unknown";
        if (op == 6'h00 && fn == 6'h2a) begin
            ew = 1'b1; er = (sval(rs) < sval(rt)) ? 1 : 0; tag = "R2 slt";
        end else if (op == 6'h00 && fn == 6'h2b) begin
            ew = 1'b1; er = (int'(rs) < int'(rt)) ? 1 : 0; tag = "R3 sltu";
        end else if (op == 6'h00 && fn == 6'h0a) begin
            if (rt == 0) begin ew = 1'b1; er = rs; tag = "R6 movz"; end
            else begin ew = 1'b0; er = old; tag = "R8 movz hold"; end
        end else if (op == 6'h00 && fn == 6'h0b) begin
            if (rt != 0) begin ew = 1'b1; er = rs; tag = "R7 movn"; end
            else begin ew = 1'b0; er = old; tag = "R8 movn hold"; end
        end else if (op == 6'h0a) begin
            ew = 1'b1; er = (sval(rs) < sval(immx)) ? 1 : 0; tag = "R4 slti";
        end else if (op == 6'h0b) begin
            ew = 1'b1; er = (int'(rs) < int'(immx)) ? 1 : 0; tag = "R5 sltiu";
        end
        s_op = op; s_fn = fn; s_rs = rs; s_rt = rt; s_imm = imm; s_old = old;
        @(negedge clk);
        check(tag, {28'd0, s_we, s_res}, {28'd0, ew, er});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low even with a firing compare applied
        b_op = 6'h00; b_fn = 6'h2b; b_rs = 32'd1; b_rt = 32'd2;
        repeat (3) @(negedge clk);
        check("R1 reset", {b_we, b_res}, 33'd0);
        rst_n = 1'b1;
        b_op = 6'h3f;
        @(negedge clk);
        // R1 latency: new inputs, output unchanged until the next rising edge
        b_op = 6'h00; b_fn = 6'h2b; b_rs = 32'd1; b_rt = 32'd2;
        #1;
        check("R1 latency before edge", {b_we, b_res}, 33'd0);
        @(negedge clk);
        check("R1 latency after edge", {b_we, b_res}, {1'b1, 32'd1});

        run_big("R10 slt signed", 6'h00, 6'h2a, 32'd1, 32'hFFFF_FFFF, 16'h0, 32'h0, 32'd0, 1'b1);
        run_big("R10 sltu unsigned", 6'h00, 6'h2b, 32'd1, 32'hFFFF_FFFF, 16'h0, 32'h0, 32'd1, 1'b1);
        run_big("R2 slt negative", 6'h00, 6'h2a, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 32'h0, 32'd1, 1'b1);
        run_big("R3 sltu equal", 6'h00, 6'h2b, 32'h1234_5678, 32'h1234_5678, 16'h0, 32'h0, 32'd0, 1'b1);
        run_big("R4 slti neg rs", 6'h0a, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'h0000, 32'h0, 32'd1, 1'b1);
        run_big("R4 slti neg imm", 6'h0a, 6'h00, 32'd0, 32'h0, 16'h8000, 32'h0, 32'd0, 1'b1);
        run_big("R5 sltiu sext imm", 6'h0b, 6'h00, 32'd0, 32'h0, 16'h8000, 32'h0, 32'd1, 1'b1);
        run_big("R5 sltiu above", 6'h0b, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 32'h0, 32'd0, 1'b1);
        run_big("R6 movz take", 6'h00, 6'h0a, 32'hDEAD_BEEF, 32'h0, 16'h0, 32'h5555_5555, 32'hDEAD_BEEF, 1'b1);
        run_big("R8 movz hold", 6'h00, 6'h0a, 32'hDEAD_BEEF, 32'h1, 16'h0, 32'h5555_5555, 32'h5555_5555, 1'b0);
        run_big("R7 movn take", 6'h00, 6'h0b, 32'hCAFE_0001, 32'h8000_0000, 16'h0, 32'hA5A5_A5A5, 32'hCAFE_0001, 1'b1);
        run_big("R8 movn hold", 6'h00, 6'h0b, 32'hCAFE_0001, 32'h0, 16'h0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0);
        run_big("R9 bad opcode", 6'h23, 6'h2a, 32'd1, 32'd2, 16'h7, 32'hFFFF_FFFF, 32'd0, 1'b0);
        run_big("R9 bad funct", 6'h00, 6'h20, 32'd1, 32'd2, 16'h7, 32'hFFFF_FFFF, 32'd0, 1'b0);

        // exhaustive sweeps on the small instance
        for (int rs = 0; rs < (1 << SW); rs++) begin
            for (int rt = 0; rt < (1 << SW); rt++) begin
                run_small(6'h00, 6'h2a, SW'(rs), SW'(rt), '0);
                run_small(6'h00, 6'h2b, SW'(rs), SW'(rt), '0);
                run_small(6'h00, 6'h0a, SW'(rs), SW'(rt), '0);
                run_small(6'h00, 6'h0b, SW'(rs), SW'(rt), '0);
            end
            for (int im = 0; im < (1 << SI); im++) begin
                run_small(6'h0a, 6'h00, SW'(rs), SW'(3), SI'(im));
                run_small(6'h0b, 6'h00, SW'(rs), SW'(3), SI'(im));
            end
        end
        for (int fn = 0; fn < 64; fn++) begin
            if (fn != 6'h2a && fn != 6'h2b && fn != 6'h0a && fn != 6'h0b)
                run_small(6'h00, 6'(fn), 4'h7, 4'h0, 3'h5);
        end
        for (int op = 1; op < 64; op++) begin
            if (op != 6'h0a && op != 6'h0b)
                run_small(6'(op), 6'h2a, 4'h1, 4'h2, 3'h3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule